// File: doc/BRIEF.md
# Shared Dual-Latency RAM Arbiter

This block is a byte-wide on-chip RAM that two masters share. A fast controller port finishes each read or write in one clock. A system-bus port serves whichever bus master currently owns the system bus, and it finishes each access in three clocks under a request/acknowledge handshake. Arbitration among the bus masters happens upstream and is not part of this block.

Both ports access the storage on the clock edge at which their request is taken. If the system port takes a request on the same edge as a fast-port access and either access writes, the fast access is held for exactly one clock. The system port is never delayed. If both accesses only read, both proceed on that edge.

The byte address space has two mapped regions: a general region and a parameter region. A gap separates them, and every address outside the two regions is unmapped. The fast port has a separate instruction-fetch qualifier. An instruction fetch is allowed only inside a window of the general region. A fetch outside that window is refused and raises an error flag.

Top module: `shram_arbiter`

## Requirements
- R1: A fast-port request sampled on edge k, with no conflict and no held access pending, raises `f_done` for the cycle after edge k. A read returns its data on `f_rdata` in that same cycle.
- R2: A system request is taken on an edge only when the port is idle. `s_ack` is high for exactly one cycle: the third cycle after the edge that took the request. `s_rdata` holds the read byte while `s_ack` is high, and holds zero for a write.
- R3: When the system port takes a request on the same edge as a fast-port request, and either of them writes, the fast access is held. `f_stall` is high and `f_done` is low for one cycle. The fast access then executes on the next edge, and `f_done` rises one cycle later than it would have without the conflict.
- R4: When the system port takes a read on the same edge as a fast-port read or fetch, neither port stalls. `f_done` follows as in R1.
- R5: The general region spans byte addresses 0x000–0x6FF (1792 bytes). The parameter region spans 0x800–0xAFF (768 bytes). Both ports can read and write every mapped byte, and a byte written by either port is read back by both.
- R6: A write to an unmapped address (0x700–0x7FF or 0xB00–0xFFF) changes no stored byte. A read from an unmapped address returns zero.
- R7: `f_fetch` high marks a fast-port read as an instruction fetch, and `f_we` is then ignored. A fetch inside 0x200–0x5FF returns the stored byte with `f_err` low. A fetch outside that window returns zero with `f_err` high, in the cycle where `f_done` is high.
- R8: When both ports write the same byte on the same edge, the system write is applied first and the held fast write one edge later. The fast port's value is the one that remains.
- R9: While reset is high and in the first cycle after it, `f_done`, `f_stall`, `f_err` and `s_ack` are low, and the system port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_req | input | 1 | Fast-port access request for this cycle |
| f_we | input | 1 | Fast-port write enable |
| f_fetch | input | 1 | Fast-port instruction-fetch qualifier |
| f_addr | input | 12 | Fast-port byte address |
| f_wdata | input | 8 | Fast-port write byte |
| f_done | output | 1 | Fast access completed in this cycle |
| f_stall | output | 1 | Fast access held by a conflict |
| f_err | output | 1 | Fetch refused: address outside the fetch window |
| f_rdata | output | 8 | Fast-port read byte |
| s_req | input | 1 | System-bus request, held until acknowledged |
| s_we | input | 1 | System-bus write enable |
| s_addr | input | 12 | System-bus byte address |
| s_wdata | input | 8 | System-bus write byte |
| s_ack | output | 1 | System access acknowledge, one-cycle pulse |
| s_rdata | output | 8 | System-bus read byte, valid with `s_ack` |

## Verification
The assertions assume two things about the inputs. The fast requester keeps `f_req` low while `f_stall` is high. The system requester drops `s_req` in its acknowledge cycle, so each request is taken only once. The random stimulus meets both. It forces `f_req` low whenever the bench model holds a fast access. It keeps the system request and its fields stable from issue until the acknowledge cycle, and releases the request in that cycle. Random addresses are weighted across both regions, the gap and the upper unmapped range, so conflicts, fetch refusals and unmapped accesses occur often. Directed cases cover a same-byte double write and a simultaneous read pair.

// File: rtl/shram_pkg.sv
package shram_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 8;
    localparam int GEN_BYTES = 1792;
    localparam int PRM_BYTES = 768;
    localparam int PRM_BASE  = 'h800;
    localparam int UC_LO     = 'h200;
    localparam int UC_HI     = 'h5FF;
    localparam int DEPTH     = GEN_BYTES + PRM_BYTES;
    localparam int IDX_W     = $clog2(DEPTH);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  we;
        logic  fetch;
        addr_t addr;
        byte_t wdata;
    } fast_op_t;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } map_t;

    typedef enum logic [1:0] {
        SYS_IDLE  = 2'd0,
        SYS_HOLD1 = 2'd1,
        SYS_HOLD2 = 2'd2,
        SYS_ACK   = 2'd3
    } sys_state_t;

    function automatic map_t map_addr(input addr_t a);
        map_t m;
        int   ai;
        ai    = int'(a);
        m.hit = 1'b0;
        m.idx = '0;
        if (ai < GEN_BYTES) begin
            m.hit = 1'b1;
            m.idx = idx_t'(ai);
        end else if (ai >= PRM_BASE && ai < PRM_BASE + PRM_BYTES) begin
            m.hit = 1'b1;
            m.idx = idx_t'(ai - PRM_BASE + GEN_BYTES);
        end
        return m;
    endfunction

    function automatic logic in_fetch_window(input addr_t a);
        return (int'(a) >= UC_LO) && (int'(a) <= UC_HI);
    endfunction

endpackage

// File: rtl/shram_store.sv
module shram_store
    import shram_pkg::*;
#(
    parameter int N  = DEPTH,
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b
);
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data_a = mem[rd_idx_a];
    assign rd_data_b = mem[rd_idx_b];
endmodule

// File: rtl/shram_sys_port.sv
module shram_sys_port
    import shram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  s_req,
    input  logic  s_we,
    input  addr_t s_addr,
    input  byte_t s_wdata,
    input  byte_t rd_val,
    output logic  go,
    output logic  wr_en,
    output idx_t  idx,
    output byte_t wr_data,
    output logic  s_ack,
    output byte_t s_rdata
);
    sys_state_t st_q, st_d;
    map_t       m;
    byte_t      rd_q;

    assign m       = map_addr(s_addr);
    assign go      = (st_q == SYS_IDLE) && s_req;
    assign wr_en   = go && s_we && m.hit;
    assign idx     = m.idx;
    assign wr_data = s_wdata;

    always_comb begin
        unique case (st_q)
            SYS_IDLE:  st_d = go ? SYS_HOLD1 : SYS_IDLE;
            SYS_HOLD1: st_d = SYS_HOLD2;
            SYS_HOLD2: st_d = SYS_ACK;
            default:   st_d = SYS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SYS_IDLE;
            rd_q <= '0;
        end else begin
            st_q <= st_d;
            if (go) rd_q <= (m.hit && !s_we) ? rd_val : '0;
        end
    end

    assign s_ack   = (st_q == SYS_ACK);
    assign s_rdata = rd_q;
endmodule

// File: rtl/shram_fast_port.sv
module shram_fast_port
    import shram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  f_req,
    input  logic  f_we,
    input  logic  f_fetch,
    input  addr_t f_addr,
    input  byte_t f_wdata,
    input  logic  sys_go,
    input  logic  sys_we,
    input  byte_t rd_val,
    output logic  conflict,
    output logic  wr_en,
    output idx_t  idx,
    output byte_t wr_data,
    output logic  f_done,
    output logic  f_stall,
    output logic  f_err,
    output byte_t f_rdata
);
    fast_op_t live_op, held_q, op;
    logic     held_v, live, act;
    map_t     m;
    byte_t    res;
    logic     res_err;

    assign live_op  = '{we: f_we && !f_fetch, fetch: f_fetch, addr: f_addr, wdata: f_wdata};
    assign live     = f_req && !held_v;
    assign conflict = live && sys_go && (sys_we || live_op.we);
    assign act      = held_v || (live && !conflict);
    assign op       = held_v ? held_q : live_op;
    assign m        = map_addr(op.addr);
    assign idx      = m.idx;
    assign wr_en    = act && op.we && m.hit;
    assign wr_data  = op.wdata;

    always_comb begin
        res     = '0;
        res_err = 1'b0;
        if (op.fetch) begin
            if (in_fetch_window(op.addr)) res = rd_val;
            else                          res_err = 1'b1;
        end else if (!op.we && m.hit) begin
            res = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v  <= 1'b0;
            held_q  <= '0;
            f_done  <= 1'b0;
            f_err   <= 1'b0;
            f_rdata <= '0;
        end else begin
            held_v <= conflict;
            if (conflict) held_q <= live_op;
            f_done <= act;
            f_err  <= act && res_err;
            if (act) f_rdata <= res;
        end
    end

    assign f_stall = held_v;
endmodule

// File: rtl/shram_arbiter.sv
module shram_arbiter
    import shram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        f_req,
    input  logic        f_we,
    input  logic        f_fetch,
    input  logic [11:0] f_addr,
    input  logic [7:0]  f_wdata,
    output logic        f_done,
    output logic        f_stall,
    output logic        f_err,
    output logic [7:0]  f_rdata,
    input  logic        s_req,
    input  logic        s_we,
    input  logic [11:0] s_addr,
    input  logic [7:0]  s_wdata,
    output logic        s_ack,
    output logic [7:0]  s_rdata
);
    logic  sys_go, sys_wr, fst_wr, conflict;
    idx_t  sys_idx, fst_idx;
    byte_t sys_wd, fst_wd, sys_rd, fst_rd;

    shram_sys_port u_sys (
        .clk(clk), .rst(rst), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .rd_val(sys_rd), .go(sys_go), .wr_en(sys_wr),
        .idx(sys_idx), .wr_data(sys_wd), .s_ack(s_ack), .s_rdata(s_rdata)
    );

    shram_fast_port u_fast (
        .clk(clk), .rst(rst), .f_req(f_req), .f_we(f_we), .f_fetch(f_fetch),
        .f_addr(f_addr), .f_wdata(f_wdata), .sys_go(sys_go), .sys_we(s_we),
        .rd_val(fst_rd), .conflict(conflict), .wr_en(fst_wr), .idx(fst_idx),
        .wr_data(fst_wd), .f_done(f_done), .f_stall(f_stall), .f_err(f_err),
        .f_rdata(f_rdata)
    );

    // A write on either side forces the other side off the array, so one write port suffices.
    shram_store u_mem (
        .clk(clk), .wr_en(sys_wr || fst_wr),
        .wr_idx(sys_wr ? sys_idx : fst_idx),
        .wr_data(sys_wr ? sys_wd : fst_wd),
        .rd_idx_a(sys_idx), .rd_idx_b(fst_idx),
        .rd_data_a(sys_rd), .rd_data_b(fst_rd)
    );
endmodule

// File: rtl/shram_arbiter_chk.sv
module shram_arbiter_chk (
    input logic       clk,
    input logic       rst,
    input logic       f_req,
    input logic       f_we,
    input logic       f_fetch,
    input logic       s_we,
    input logic       sys_go,
    input logic       s_ack,
    input logic       f_done,
    input logic       f_stall,
    input logic       f_err,
    input logic [7:0] f_rdata
);
    logic fast_wr;
    assign fast_wr = f_we && !f_fetch;

    p_fast_single_r1: assert property (@(posedge clk) disable iff (rst)
        (f_req && !f_stall && !sys_go) |=> f_done);

    p_ack_third_r2: assert property (@(posedge clk) disable iff (rst)
        sys_go |-> ##3 s_ack);

    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        s_ack |=> !s_ack);

    p_no_early_ack_r2: assert property (@(posedge clk) disable iff (rst)
        sys_go |=> !s_ack);

    p_hold_one_r3: assert property (@(posedge clk) disable iff (rst)
        (sys_go && f_req && !f_stall && (s_we || fast_wr)) |=> (f_stall && !f_done));

    p_done_late_r3: assert property (@(posedge clk) disable iff (rst)
        (sys_go && f_req && !f_stall && (s_we || fast_wr)) |-> ##2 (f_done && !f_stall));

    p_stall_short_r3: assert property (@(posedge clk) disable iff (rst)
        f_stall |=> !f_stall);

    p_reads_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (sys_go && f_req && !f_stall && !s_we && !fast_wr) |=> (f_done && !f_stall));

    p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
        f_err |-> (f_done && f_rdata == 8'h00));
endmodule

bind shram_arbiter shram_arbiter_chk u_chk (
    .clk(clk), .rst(rst), .f_req(f_req), .f_we(f_we), .f_fetch(f_fetch),
    .s_we(s_we), .sys_go(sys_go), .s_ack(s_ack), .f_done(f_done),
    .f_stall(f_stall), .f_err(f_err), .f_rdata(f_rdata)
);

// File: tb/tb_shram_arbiter.sv
`timescale 1ns/1ps
module tb_shram_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        f_req = 0, f_we = 0, f_fetch = 0;
    logic [11:0] f_addr = '0;
    logic [7:0]  f_wdata = '0;
    logic        f_done, f_stall, f_err;
    logic [7:0]  f_rdata;
    logic        s_req = 0, s_we = 0;
    logic [11:0] s_addr = '0;
    logic [7:0]  s_wdata = '0;
    logic        s_ack;
    logic [7:0]  s_rdata;

    always #5 clk = ~clk;

    shram_arbiter dut (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // bench reference state
    logic [7:0] mdl [4096];
    int         scnt = 0;
    bit         pend = 0;
    bit         p_we, p_fe;
    logic [11:0] p_a;
    logic [7:0]  p_d;
    bit          e_fdone = 0, e_fstall = 0, e_ferr = 0, e_sack = 0;
    logic [7:0]  e_frd = '0, e_srd = '0;
    string       fast_tag = "R9", data_tag = "R5";

    function automatic bit mapped(input logic [11:0] a);
        return (a < 12'h700) || (a >= 12'h800 && a < 12'hB00);
    endfunction

    function automatic bit in_win(input logic [11:0] a);
        return a >= 12'h200 && a <= 12'h5FF;
    endfunction

    function automatic logic [11:0] rnd_addr();
        case ($urandom % 8)
            0, 1, 2: return 12'($urandom % 'h700);
            3:       return 12'h200 + 12'($urandom % 'h400);
            4, 5:    return 12'h800 + 12'($urandom % 'h300);
            6:       return 12'h700 + 12'($urandom % 'h100);
            default: return 12'hB00 + 12'($urandom % 'h500);
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(f_done === e_fdone, fast_tag, "f_done", 32'(f_done), 32'(e_fdone));
        check(f_stall === e_fstall, "R3", "f_stall", 32'(f_stall), 32'(e_fstall));
        check(s_ack === e_sack, "R2", "s_ack", 32'(s_ack), 32'(e_sack));
        if (e_fdone) begin
            check(f_err === e_ferr, "R7", "f_err", 32'(f_err), 32'(e_ferr));
            check(f_rdata === e_frd, e_ferr ? "R7" : data_tag, "f_rdata", 32'(f_rdata), 32'(e_frd));
        end
        if (e_sack)
            check(s_rdata === e_srd, data_tag, "s_rdata", 32'(s_rdata), 32'(e_srd));
    endtask

    // predicts the effect of the coming rising edge
    task automatic model_edge();
        bit sgo, act, o_we, o_fe, pend_n;
        logic [11:0] o_a;
        logic [7:0]  o_d, fr;
        sgo = (scnt == 0) && s_req;
        act = 0; pend_n = 0;
        o_we = 0; o_fe = 0; o_a = '0; o_d = '0;
        fast_tag = "R1";
        if (pend) begin
            act = 1; o_we = p_we; o_fe = p_fe; o_a = p_a; o_d = p_d;
            fast_tag = "R3";
        end else if (f_req) begin
            o_we = f_we && !f_fetch; o_fe = f_fetch; o_a = f_addr; o_d = f_wdata;
            if (sgo && (s_we || o_we)) begin
                pend_n = 1; p_we = o_we; p_fe = o_fe; p_a = o_a; p_d = o_d;
                fast_tag = "R3";
            end else begin
                act = 1;
                if (sgo) fast_tag = "R4";
            end
        end
        fr = '0;
        e_ferr = 0;
        if (act) begin
            if (o_fe) begin
                if (in_win(o_a)) fr = mdl[o_a];
                else e_ferr = 1;
            end else if (!o_we && mapped(o_a)) fr = mdl[o_a];
            e_frd = fr;
        end
        if (sgo) e_srd = (!s_we && mapped(s_addr)) ? mdl[s_addr] : 8'h00;
        if (sgo && s_we && mapped(s_addr)) mdl[s_addr] = s_wdata;
        if (act && o_we && mapped(o_a)) mdl[o_a] = o_d;
        e_fdone = act;
        e_fstall = pend_n;
        pend = pend_n;
        if (sgo) scnt = 1;
        else if (scnt != 0) scnt = (scnt == 3) ? 0 : scnt + 1;
        e_sack = (scnt == 3);
    endtask

    task automatic step(input bit fr, input bit fwe, input bit ffe,
                        input logic [11:0] fa, input logic [7:0] fwd,
                        input bit sr, input bit swe,
                        input logic [11:0] sa, input logic [7:0] swd);
        @(negedge clk);
        compare();
        if (scnt == 0) begin
            s_req = sr; s_we = swe; s_addr = sa; s_wdata = swd;
        end else if (scnt == 3) begin
            s_req = 0;
        end
        f_req = pend ? 1'b0 : fr;
        f_we = fwe; f_fetch = ffe; f_addr = fa; f_wdata = fwd;
        model_edge();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, 0, 0, '0, '0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 4096; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: quiet outputs during reset
        check(!f_done && !f_stall && !f_err && !s_ack, "R9", "outputs in reset",
              32'({f_done, f_stall, f_err, s_ack}), 32'h0);
        rst = 0;
        @(negedge clk);
        check(!f_done && !f_stall && !f_err && !s_ack, "R9", "outputs after reset",
              32'({f_done, f_stall, f_err, s_ack}), 32'h0);
        fast_tag = "R9";
        // R9: system port takes a request right away
        step(0, 0, 0, '0, '0, 1, 0, 12'h700, '0);
        idle(4);

        // R5: fill every mapped byte through the fast port
        for (int a = 0; a < 4096; a++)
            if (mapped(12'(a))) step(1, 1, 0, 12'(a), 8'(a ^ (a >> 4) ^ 8'h5A), 0, 0, '0, '0);
        idle(2);

        // R6: unmapped writes from both ports, then read back
        data_tag = "R6";
        step(1, 1, 0, 12'h7A0, 8'hEE, 0, 0, '0, '0);
        step(0, 0, 0, '0, '0, 1, 1, 12'hC10, 8'hDD);
        idle(4);
        step(1, 0, 0, 12'h7A0, '0, 1, 0, 12'hC10, '0);
        idle(4);
        step(1, 0, 0, 12'h6FF, '0, 1, 0, 12'hAFF, '0);
        idle(4);

        // R8: same byte written by both ports on one edge
        data_tag = "R8";
        step(1, 1, 0, 12'h123, 8'hA1, 1, 1, 12'h123, 8'hB2);
        idle(4);
        step(1, 0, 0, 12'h123, '0, 1, 0, 12'h123, '0);
        idle(4);

        // R4: simultaneous reads; R7: fetch in and out of window
        data_tag = "R4";
        step(1, 0, 1, 12'h200, '0, 1, 0, 12'h850, '0);
        idle(4);
        step(1, 1, 1, 12'h1FF, 8'h77, 0, 0, '0, '0);
        step(1, 0, 1, 12'h5FF, '0, 0, 0, '0, '0);
        step(1, 0, 1, 12'h600, '0, 0, 0, '0, '0);
        step(1, 0, 1, 12'h900, '0, 0, 0, '0, '0);
        idle(2);

        // random mix
        data_tag = "R5";
        for (int i = 0; i < 30000; i++) begin
            bit fr, fwe, ffe, sr, swe;
            fr  = ($urandom % 3) != 0;
            ffe = ($urandom % 4) == 0;
            fwe = ($urandom % 2) == 0;
            sr  = ($urandom % 2) == 0;
            swe = ($urandom % 2) == 0;
            step(fr, fwe, ffe, rnd_addr(), 8'($urandom), sr, swe, rnd_addr(), 8'($urandom));
        end
        idle(6);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule